// File: doc/BRIEF.md
# Serial Port Status and Flag Controller

This block is the register side of an asynchronous serial port. Software reaches it over a small byte-wide bus with a 3-bit address. Through that bus it can reach a frame-format register, a control register holding the transmit enable, a transmit holding register, a read-only receive data register and a status register. The status register carries five hardware flags: transmitter ready, receive buffer full, overrun, framing error and parity error. Each flag is set only by a hardware event. Software can clear a flag, and only by writing a zero to that bit position. A bit written with one keeps its value, so one flag can be cleared by writing the register back with only that bit lowered.

Received characters arrive as single-cycle parallel strobes that carry their error indications. Written characters leave as single-cycle strobes, but only while transmission is enabled. Once software has written a character and cleared the transmitter-ready flag, the flag is held low for one full character time, and a busy output is high for that same span. The character time is the number of system clocks that one frame occupies at the configured bit rate. It is chosen from a small table built at elaboration from the clock and bit-rate parameters, and the table entry is selected by the frame format, so no division happens at run time. Line serialisation, bit-rate clock generation and interrupts are handled by neighbouring logic.

Top module: `sport_flagctl`

## Requirements
- R1: After reset, every register reads 0x00, `tx_busy` is 0, no character is emitted, and the character time is that of format 0x00 (8 data bits, no parity, 1 stop bit).
- R2: A status write (address 3) never sets any of the five flags; writing 0xF8 to an all-zero status register leaves it reading 0x00.
- R3: A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. The flag positions are: bit 7 transmitter ready, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error.
- R4: Writing the control register (address 1) with bit 0 (transmit enable) going from 0 to 1 sets the transmitter-ready flag, unless the character timer is running.
- R5: A write to the transmit register (address 2) while transmit enable is 0 emits nothing. While it is 1, every write produces exactly one `tx_emit` pulse, on the clock after the write, with `tx_byte` equal to the written value, and pulses come in write order.
- R6: When a character has been written since the last timer start and a status write clears a set transmitter-ready flag, `tx_busy` rises and the flag stays 0 for N-1 following clocks. On the N-th clock the flag reads 1 and `tx_busy` reads 0, where N is the character time.
- R7: N = round(bits × CLK_HZ / BAUD), where bits = 1 + data + parity + stop. Format register (address 0) fields: bit 6 selects 7 data bits (else 8), bit 5 adds a parity bit, bit 4 selects odd parity, bit 3 selects 2 stop bits (else 1). Other bits are stored only. At the defaults, 0x00 gives 2604, 0x24 (8 data, even parity, 1 stop) gives 2865, 0x40 gives 2344 and 0x2C gives 3125. The value is taken when the format is written.
- R8: A received strobe while receive full is 0 loads the receive register (address 4), sets receive full, and sets the framing and parity flags when the strobe reports those errors.
- R9: A received strobe while receive full is 1 sets overrun, leaves the receive register unchanged and records neither error indication of the dropped character.
- R10: Status bits 2:0 read back the last value written to them, and hardware events never change them.
- R11: When a hardware set and a software clear hit the same flag in the same clock, the flag ends set. Receive arrival is judged against the receive-full value from before that clock's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address: 0 format, 1 control, 2 transmit, 3 status, 4 receive |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational, no read side effects |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Received character had a bad stop bit |
| rx_parity_err | input | 1 | Received character had a parity mismatch |
| tx_emit | output | 1 | One-cycle pulse: a character is handed to the line |
| tx_byte | output | 8 | Character handed over with `tx_emit` |
| tx_busy | output | 1 | Character timer running |

## Verification
A wrong flag-update state shows up on the first status read after the offending clock: a bit set by a write, a bit kept when it should be cleared, or a reserved bit disturbed by a receive strobe. A timer loaded with a wrong count or started from the wrong condition shows only at the end of the character. The transmitter-ready flag then returns one or more clocks early or late, or never returns while `tx_busy` stays high, so the bench counts clocks exactly to the expected edge for four frame formats. Overrun faults show in the same read as the flag, because the receive register must still hold the first character.

// File: rtl/sport_pkg.sv
package sport_pkg;

  localparam int unsigned FLAG_N   = 5;
  localparam int unsigned RSV_W    = 3;
  localparam int unsigned MIN_BITS = 9;
  localparam int unsigned MAX_BITS = 12;
  localparam int unsigned N_FMT    = MAX_BITS - MIN_BITS + 1;

  // flag index inside the 5-bit flag vector (vector bit i sits at status bit i+3)
  localparam int unsigned F_PAR  = 0;
  localparam int unsigned F_FER  = 1;
  localparam int unsigned F_OVR  = 2;
  localparam int unsigned F_RDRF = 3;
  localparam int unsigned F_TDRE = 4;

  typedef enum logic [2:0] {
    A_FMT  = 3'd0,
    A_CTRL = 3'd1,
    A_TXD  = 3'd2,
    A_STAT = 3'd3,
    A_RXD  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic seven;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [7:0] m);
    frame_fmt_t f;
    f.seven    = m[6];
    f.par_en   = m[5];
    f.par_odd  = m[4];
    f.two_stop = m[3];
    return f;
  endfunction

  function automatic int unsigned frame_bits(input frame_fmt_t f);
    int unsigned n;
    n = 1;
    n += f.seven ? 7 : 8;
    n += f.par_en ? 1 : 0;
    n += f.two_stop ? 2 : 1;
    return n;
  endfunction

  // round-to-nearest clocks per frame; only called on constants
  function automatic longint unsigned char_clocks(input int unsigned bits,
                                                  input longint unsigned clk_hz,
                                                  input longint unsigned baud);
    longint unsigned num;
    num = longint'(bits) * clk_hz + baud / 2;
    return num / baud;
  endfunction

endpackage

// File: rtl/sport_fmt.sv
module sport_fmt
  import sport_pkg::*;
#(
  parameter int unsigned CLK_HZ = 10_000_000,
  parameter int unsigned BAUD   = 38_400,
  parameter int unsigned CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_wr,
  input  logic [7:0]       fmt_wdata,
  output logic [7:0]       fmt_q,
  output logic [CNT_W-1:0] char_clks
);

  localparam int unsigned IDX_W = $clog2(N_FMT);
  localparam logic [CNT_W-1:0] RESET_CLKS =
    CNT_W'(char_clocks(frame_bits(decode_fmt(8'h00)), CLK_HZ, BAUD));

  logic [CNT_W-1:0] clk_lut [N_FMT];

  for (genvar i = 0; i < N_FMT; i++) begin : g_lut
    localparam longint unsigned CLKS = char_clocks(MIN_BITS + i, CLK_HZ, BAUD);
    assign clk_lut[i] = CNT_W'(CLKS);
  end

  frame_fmt_t       new_fmt;
  logic [IDX_W-1:0] new_idx;

  assign new_fmt = decode_fmt(fmt_wdata);
  assign new_idx = IDX_W'(frame_bits(new_fmt) - MIN_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q     <= 8'h00;
      char_clks <= RESET_CLKS;
    end else if (fmt_wr) begin
      fmt_q     <= fmt_wdata;
      char_clks <= clk_lut[new_idx];
    end
  end

  // R7: the character time changes only through a format write
  p_char_only_on_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_wr |=> $stable(char_clks));

  // R7: a loaded character time is never zero
  p_char_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    char_clks != '0);

endmodule

// File: rtl/sport_txctl.sv
module sport_txctl
  import sport_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             txd_wr,
  input  logic [7:0]       wdata,
  input  logic             tdre_clr_wr,
  input  logic             tdre_now,
  input  logic [CNT_W-1:0] char_clks,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       txd_q,
  output logic             tx_emit,
  output logic [7:0]       tx_byte,
  output logic             tx_busy,
  output logic             tdre_set
);

  logic             te;
  logic             te_rise;
  logic             send;
  logic             pending_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tmr_start;
  logic             tmr_done;

  assign te        = ctrl_q[0];
  assign te_rise   = ctrl_wr & wdata[0] & ~te;
  assign send      = txd_wr & te;
  assign tmr_start = tdre_clr_wr & tdre_now & pending_q & ~tx_busy;
  assign tmr_done  = tx_busy & (cnt_q == CNT_W'(1));
  assign tdre_set  = (te_rise & ~tx_busy) | tmr_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      txd_q  <= 8'h00;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (txd_wr)  txd_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_emit   <= 1'b0;
      tx_byte   <= 8'h00;
      pending_q <= 1'b0;
    end else begin
      tx_emit <= send;
      if (send) tx_byte <= wdata;
      if (tmr_start)  pending_q <= 1'b0;
      else if (send)  pending_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      cnt_q   <= '0;
    end else if (tmr_start) begin
      tx_busy <= 1'b1;
      cnt_q   <= char_clks;
    end else if (tmr_done) begin
      tx_busy <= 1'b0;
      cnt_q   <= '0;
    end else if (tx_busy) begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  // R5: no emission while transmit enable is clear
  p_no_emit_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !te) |=> !tx_emit);

  // R6: a running timer always holds a live count
  p_busy_count_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (cnt_q != '0));

  // R6: busy stays up until the count expires, then drops
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tmr_done) |=> tx_busy);
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> !tx_busy);

endmodule

// File: rtl/sport_rxcap.sv
module sport_rxcap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_frame_err,
  input  logic       rx_parity_err,
  input  logic       rdrf_now,
  output logic [7:0] rdr_q,
  output logic       rdrf_set,
  output logic       ovr_set,
  output logic       fer_set,
  output logic       per_set
);

  logic accept;

  assign accept   = rx_valid & ~rdrf_now;
  assign rdrf_set = accept;
  assign ovr_set  = rx_valid & rdrf_now;
  assign fer_set  = accept & rx_frame_err;
  assign per_set  = accept & rx_parity_err;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdr_q <= 8'h00;
    else if (accept) rdr_q <= rx_data;
  end

  // R9: a character arriving into a full buffer leaves the held one intact
  p_keep_on_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rdrf_now) |=> $stable(rdr_q));

  // R8: the receive register changes only on an accepted strobe
  p_rdr_only_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rdr_q));

endmodule

// File: rtl/sport_flags.sv
module sport_flags
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_wr,
  input  logic [7:0]        st_wdata,
  input  logic [FLAG_N-1:0] hw_set,
  output logic [FLAG_N-1:0] flags_q,
  output logic [RSV_W-1:0]  rsv_q
);

  logic [FLAG_N-1:0] sw_keep;

  assign sw_keep = st_wr ? st_wdata[7 -: FLAG_N] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      rsv_q   <= '0;
    end else begin
      flags_q <= (flags_q & sw_keep) | hw_set;
      if (st_wr) rsv_q <= st_wdata[RSV_W-1:0];
    end
  end

  // R2: a flag rises only where hardware asked for it
  p_no_set_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(hw_set)) == '0));

  // R3: with no hardware event, a status write acts as a clear mask
  p_write_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && hw_set == '0) |=> (flags_q == ($past(flags_q) & $past(st_wdata[7:3]))));

  // R11: a hardware set always lands, whatever the bus did
  p_hw_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags_q & $past(hw_set)) == $past(hw_set)));

  // R10: reserved bits move only on a status write
  p_rsv_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> $stable(rsv_q));

endmodule

// File: rtl/sport_flagctl.sv
module sport_flagctl
  import sport_pkg::*;
#(
  parameter int unsigned CLK_HZ = 10_000_000,
  parameter int unsigned BAUD   = 38_400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_frame_err,
  input  logic       rx_parity_err,
  output logic       tx_emit,
  output logic [7:0] tx_byte,
  output logic       tx_busy
);

  localparam longint unsigned MAX_CLKS = char_clocks(MAX_BITS, CLK_HZ, BAUD);
  localparam int unsigned     CNT_W    = $clog2(MAX_CLKS + 1);

  // decoded write strobes
  logic fmt_wr, ctrl_wr, txd_wr, st_wr, tdre_clr_wr;

  assign fmt_wr      = bus_wr & (bus_addr == A_FMT);
  assign ctrl_wr     = bus_wr & (bus_addr == A_CTRL);
  assign txd_wr      = bus_wr & (bus_addr == A_TXD);
  assign st_wr       = bus_wr & (bus_addr == A_STAT);
  assign tdre_clr_wr = st_wr & ~bus_wdata[7];

  // named internal events
  logic [7:0]        fmt_q, ctrl_q, txd_q, rdr_q;
  logic [CNT_W-1:0]  char_clks;
  logic [FLAG_N-1:0] flags_q;
  logic [RSV_W-1:0]  rsv_q;
  logic [FLAG_N-1:0] hw_set;
  logic              tdre_set, rdrf_set, ovr_set, fer_set, per_set;

  assign hw_set[F_TDRE] = tdre_set;
  assign hw_set[F_RDRF] = rdrf_set;
  assign hw_set[F_OVR]  = ovr_set;
  assign hw_set[F_FER]  = fer_set;
  assign hw_set[F_PAR]  = per_set;

  sport_fmt #(
    .CLK_HZ(CLK_HZ),
    .BAUD  (BAUD),
    .CNT_W (CNT_W)
  ) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_wr   (fmt_wr),
    .fmt_wdata(bus_wdata),
    .fmt_q    (fmt_q),
    .char_clks(char_clks)
  );

  sport_txctl #(
    .CNT_W(CNT_W)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .txd_wr     (txd_wr),
    .wdata      (bus_wdata),
    .tdre_clr_wr(tdre_clr_wr),
    .tdre_now   (flags_q[F_TDRE]),
    .char_clks  (char_clks),
    .ctrl_q     (ctrl_q),
    .txd_q      (txd_q),
    .tx_emit    (tx_emit),
    .tx_byte    (tx_byte),
    .tx_busy    (tx_busy),
    .tdre_set   (tdre_set)
  );

  sport_rxcap u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_frame_err (rx_frame_err),
    .rx_parity_err(rx_parity_err),
    .rdrf_now     (flags_q[F_RDRF]),
    .rdr_q        (rdr_q),
    .rdrf_set     (rdrf_set),
    .ovr_set      (ovr_set),
    .fer_set      (fer_set),
    .per_set      (per_set)
  );

  sport_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_wr   (st_wr),
    .st_wdata(bus_wdata),
    .hw_set  (hw_set),
    .flags_q (flags_q),
    .rsv_q   (rsv_q)
  );

  always_comb begin
    case (bus_addr)
      A_FMT:   bus_rdata = fmt_q;
      A_CTRL:  bus_rdata = ctrl_q;
      A_TXD:   bus_rdata = txd_q;
      A_STAT:  bus_rdata = {flags_q, rsv_q};
      A_RXD:   bus_rdata = rdr_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  // R6: while the timer runs the transmitter-ready flag stays low
  p_busy_tdre_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !flags_q[F_TDRE]);

  // R6: the timer's end raises the transmitter-ready flag
  p_expire_sets_tdre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> flags_q[F_TDRE]);

endmodule

// File: tb/sport_flagctl_bench.sv
module sport_flagctl_bench;

  localparam int unsigned CLK_HZ = 10_000_000;
  localparam int unsigned BAUD   = 38_400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_frame_err = 1'b0;
  logic       rx_parity_err = 1'b0;
  logic       tx_emit;
  logic [7:0] tx_byte;
  logic       tx_busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] emitted[$];

  always #4 clk = ~clk;

  sport_flagctl #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_sport_flagctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .tx_emit(tx_emit), .tx_byte(tx_byte), .tx_busy(tx_busy)
  );

  always @(negedge clk) if (rst_n && tx_emit) emitted.push_back(tx_byte);

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_parity_err = pe;
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
  endtask

  // bench's own restatement of the frame timing: doubled quotient, then halved
  function automatic int exp_clks(input logic [7:0] m);
    int bits;
    longint twice;
    bits = 2 + (m[6] ? 7 : 8) + (m[5] ? 1 : 0) + (m[3] ? 1 : 0);
    twice = (64'(bits) * 64'(CLK_HZ) * 2) / 64'(BAUD);
    return int'((twice + 1) / 2);
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reset reg %0d", a), v, 0);
    end
    check("R1 reset busy", tx_busy, 0);
    check("R1 reset emit count", emitted.size(), 0);
  endtask

  task automatic t_write_one();
    logic [7:0] v;
    wr(3'd3, 8'hF8);
    rd(3'd3, v);
    check("R2 write-one sets nothing", v, 8'h00);
    wr(3'd3, 8'hFF);
    rd(3'd3, v);
    check("R10 reserved bits read back", v, 8'h07);
  endtask

  task automatic t_tx_disabled();
    logic [7:0] v;
    wr(3'd2, 8'h33);
    repeat (3) @(negedge clk);
    check("R5 no emit while disabled", emitted.size(), 0);
    rd(3'd3, v);
    check("R5 status after disabled write", v, 8'h07);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr(3'd1, 8'h01);
    rd(3'd3, v);
    check("R4 enable sets transmitter ready", v, 8'h87);
  endtask

  task automatic t_emit_order();
    logic [7:0] v;
    logic [7:0] seq [3] = '{8'hA1, 8'h5C, 8'h3E};
    emitted.delete();
    foreach (seq[i]) wr(3'd2, seq[i]);
    repeat (2) @(negedge clk);
    check("R5 emit count", emitted.size(), 3);
    for (int i = 0; i < 3; i++)
      if (i < emitted.size()) check($sformatf("R5 emit order %0d", i), emitted[i], seq[i]);
    rd(3'd3, v);
    check("R5 ready unchanged by sends", v, 8'h87);
  endtask

  task automatic t_char_time(input logic [7:0] m);
    logic [7:0] v;
    int n;
    n = exp_clks(m);
    wr(3'd0, m);
    rd(3'd0, v);
    check("R7 format readback", v, m);
    wr(3'd2, 8'h42);
    rd(3'd3, v);
    wr(3'd3, v & 8'h7F);
    check($sformatf("R6 busy after clear fmt %0h", m), tx_busy, 1);
    repeat (n - 1) @(negedge clk);
    rd(3'd3, v);
    check($sformatf("R7 ready low at N-1 fmt %0h", m), v[7], 0);
    check($sformatf("R6 busy at N-1 fmt %0h", m), tx_busy, 1);
    @(negedge clk);
    rd(3'd3, v);
    check($sformatf("R7 ready back at N=%0d fmt %0h", n, m), v[7], 1);
    check($sformatf("R6 busy dropped fmt %0h", m), tx_busy, 0);
  endtask

  task automatic t_receive();
    logic [7:0] v;
    rx_push(8'h11, 1'b1, 1'b0);
    rd(3'd3, v); check("R8 full+framing, R10 rsv kept", v, 8'hD7);
    rd(3'd4, v); check("R8 receive data", v, 8'h11);
    rx_push(8'h22, 1'b0, 1'b1);
    rd(3'd3, v); check("R9 overrun, no parity", v, 8'hF7);
    rd(3'd4, v); check("R9 receive data kept", v, 8'h11);
    wr(3'd3, 8'hF7 & ~8'h40);
    rd(3'd3, v); check("R3 clear receive-full only", v, 8'hB7);
    rx_push(8'h33, 1'b0, 1'b1);
    rd(3'd3, v); check("R8 accept with parity error", v, 8'hFF);
    rd(3'd4, v); check("R8 new receive data", v, 8'h33);
    wr(3'd3, 8'h07);
    rd(3'd3, v); check("R3 clear all flags", v, 8'h07);
    check("R6 no timer without pending char", tx_busy, 0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    rx_push(8'h55, 1'b0, 1'b0);
    rd(3'd3, v); check("R8 full before collision", v, 8'h47);
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 8'h07; bus_wr = 1'b1;
    rx_valid = 1'b1; rx_data = 8'h66;
    @(negedge clk);
    bus_wr = 1'b0; rx_valid = 1'b0;
    rd(3'd3, v); check("R11 overrun set wins over clear", v, 8'h27);
    rd(3'd4, v); check("R11 held data kept", v, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_one();
    t_tx_disabled();
    t_enable();
    t_emit_order();
    t_char_time(8'h00);
    t_char_time(8'h24);
    t_char_time(8'h40);
    t_char_time(8'h2C);
    t_receive();
    t_collision();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule